// File: doc/BRIEF.md
# Layer-2 Address Lookup and Learning Engine

This block decides where each received frame of a five-port Ethernet switch should go. For every frame it gets the destination address, the source address, the ingress port, a filter identifier (FID) and an error flag. It returns one bit per egress port. The destination address is looked up in two places: a small table that a host writes, and a table of learned addresses. Only the learned table is consulted for the source address. Source addresses are learned, or refreshed, as a side effect of each lookup.

A lookup uses a valid/ready request channel. The scan of the learned table compares one entry per clock cycle. The answer appears on a response channel and stays there until the consumer takes it. Only one request is in flight at a time. A separate write port loads or clears host-table entries. An aging tick input advances a coarse two-bit epoch, and learned entries that have not been refreshed for three ticks are evicted.

Top module: `l2_lookup_engine`

## Requirements
- R1: A destination lookup searches both tables. A host-table hit takes precedence over a learned hit. When several host entries match, the lowest index wins.
- R2: A host entry carries a 5-bit egress mask in which bit k selects port k. On a host hit this mask is returned unchanged, so more than one bit may be set.
- R3: A host entry with its FID-qualify flag set matches only when the request FID equals the entry FID. With the flag clear, the entry matches any FID.
- R4: Learning and refresh decisions use only the learned table. A source address that is also present in the host table is still learned, and it becomes visible once the host entry is cleared.
- R5: A good frame whose source address and FID are absent from the learned table is written into the lowest-index free entry, together with its ingress port. A later destination hit on that address and FID returns the one-hot mask of the stored port. A different FID does not hit the entry.
- R6: A source hit refreshes the entry's timestamp to the current epoch and replaces its stored port with the current ingress port.
- R7: A destination address that misses in both tables is flooded: the mask has every port bit set except the ingress port.
- R8: A frame with the error flag set returns an all-zero mask and is not learned.
- R9: A frame whose destination is the flow-control PAUSE address 01-80-C2-00-00-01 returns an all-zero mask and is not learned.
- R10: Each aging tick advances a 2-bit epoch. A learned entry whose timestamp trails the epoch by three is removed, which means it survives two ticks and is gone after the third.
- R11: When no learned entry is free, the new address is not learned and no existing entry is overwritten.
- R12: A response is held stable, with rsp_valid high, until rsp_ready is taken. req_ready stays low from acceptance until the response is taken.
- R13: After reset, req_ready is high, rsp_valid is low, and both tables are empty, so any first lookup floods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine idle, request accepted |
| req_da | input | 48 | Destination MAC address |
| req_sa | input | 48 | Source MAC address |
| req_port | input | 3 | Ingress port number (0..4) |
| req_fid | input | 4 | Filter identifier |
| req_err | input | 1 | Frame received with an error |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_ports | output | 5 | Egress mask, bit k = port k |
| st_we | input | 1 | Host-table write strobe |
| st_idx | input | 3 | Host-table entry index |
| st_valid | input | 1 | Entry valid (0 clears it) |
| st_mac | input | 48 | Entry MAC address |
| st_ports | input | 5 | Entry egress mask |
| st_use_fid | input | 1 | Entry requires FID match |
| st_fid | input | 4 | Entry FID |
| age_tick | input | 1 | Advance the aging epoch |

## Verification
The assertions assume that req_port always names an existing port, below five. They also assume that rsp_ready is only meaningful while a response is pending, and that host writes do not need to be ordered against a scan that is in progress. The stimulus therefore uses port numbers 0 to 4 only. It raises rsp_ready only after rsp_valid has been seen. It pulses age_tick and writes the host table only while the engine is idle, so every expected mask follows from the sequence of completed lookups alone.

// File: rtl/l2lu_pkg.sv
// Shared constants and types for the layer-2 lookup engine.
// Assumes 48-bit MAC addresses and a 2-bit aging timestamp.
package l2lu_pkg;
    localparam int MAC_W = 48;
    localparam int TS_W  = 2;
    // Destination used by IEEE 802.3x flow-control frames.
    localparam logic [MAC_W-1:0] PAUSE_DA = 48'h0180_C200_0001;

    typedef enum logic [1:0] {
        LU_IDLE,
        LU_SCAN,
        LU_UPD,
        LU_RSP
    } lu_state_e;
endpackage

// File: rtl/l2lu_static_tbl.sv
// Host-written forwarding table, searched in parallel.
// Each entry holds a MAC, an egress mask, a FID-qualify flag and a FID.
// Assumes writes arrive from the host side and the key is stable while used.
// The lowest-index matching entry wins.
module l2lu_static_tbl
    import l2lu_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NPORTS = 5,
    parameter int FID_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic                     wr_valid,
    input  logic [MAC_W-1:0]         wr_mac,
    input  logic [NPORTS-1:0]        wr_ports,
    input  logic                     wr_use_fid,
    input  logic [FID_W-1:0]         wr_fid,
    input  logic [MAC_W-1:0]         key_mac,
    input  logic [FID_W-1:0]         key_fid,
    output logic                     hit,
    output logic [NPORTS-1:0]        hit_ports
);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0]  v_q;
    logic [MAC_W-1:0]  mac_q   [DEPTH];
    logic [NPORTS-1:0] ports_q [DEPTH];
    logic [DEPTH-1:0]  usef_q;
    logic [FID_W-1:0]  fid_q   [DEPTH];
    logic [DEPTH-1:0]  match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Entry storage: load or clear on a host write addressed here.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[i]     <= 1'b0;
                mac_q[i]   <= '0;
                ports_q[i] <= '0;
                usef_q[i]  <= 1'b0;
                fid_q[i]   <= '0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                v_q[i]     <= wr_valid;
                mac_q[i]   <= wr_mac;
                ports_q[i] <= wr_ports;
                usef_q[i]  <= wr_use_fid;
                fid_q[i]   <= wr_fid;
            end
        end

        // Per-entry compare, FID only when the entry asks for it.
        assign match[i] = v_q[i] && (mac_q[i] == key_mac) &&
                          (!usef_q[i] || (fid_q[i] == key_fid));
    end

    // Priority select: scan downwards so the lowest index is left last.
    always_comb begin
        hit       = 1'b0;
        hit_ports = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit       = 1'b1;
                hit_ports = ports_q[i];
            end
        end
    end
endmodule

// File: rtl/l2lu_dyn_tbl.sv
// Learned address table with one read port, one write port and aging.
// Each entry: valid, MAC, FID, ingress port, 2-bit timestamp.
// A write stamps the entry with the current epoch. An aging tick bumps the
// epoch, and any valid entry trailing it by three is cleared the next cycle.
// A write to an entry takes priority over its eviction.
// Assumes the controller only writes free entries or the entry that hit.
module l2lu_dyn_tbl
    import l2lu_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NPORTS = 5,
    parameter int FID_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      age_tick,
    input  logic [$clog2(DEPTH)-1:0]  rd_idx,
    output logic                      rd_valid,
    output logic [MAC_W-1:0]          rd_mac,
    output logic [FID_W-1:0]          rd_fid,
    output logic [$clog2(NPORTS)-1:0] rd_port,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  wr_idx,
    input  logic [MAC_W-1:0]          wr_mac,
    input  logic [FID_W-1:0]          wr_fid,
    input  logic [$clog2(NPORTS)-1:0] wr_port
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = $clog2(NPORTS);

    logic [TS_W-1:0]  epoch_q;
    logic [DEPTH-1:0] v_q;
    logic [MAC_W-1:0] mac_q  [DEPTH];
    logic [FID_W-1:0] fid_q  [DEPTH];
    logic [PW-1:0]    port_q [DEPTH];
    logic [TS_W-1:0]  ts_q   [DEPTH];
    logic [DEPTH-1:0] stale;

    // Global aging epoch, one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        epoch_q <= '0;
        else if (age_tick) epoch_q <= epoch_q + 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign stale[i] = (TS_W'(epoch_q - ts_q[i]) == {TS_W{1'b1}});

        // Entry storage: learn/refresh on write, evict when stale.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[i]    <= 1'b0;
                mac_q[i]  <= '0;
                fid_q[i]  <= '0;
                port_q[i] <= '0;
                ts_q[i]   <= '0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                v_q[i]    <= 1'b1;
                mac_q[i]  <= wr_mac;
                fid_q[i]  <= wr_fid;
                port_q[i] <= wr_port;
                ts_q[i]   <= epoch_q;
            end else if (v_q[i] && stale[i]) begin
                v_q[i]    <= 1'b0;
            end
        end

        // R10
        age_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (v_q[i] && stale[i] && !(wr_en && wr_idx == IW'(i))) |=> !v_q[i]);
    end

    // Read port for the linear scan.
    assign rd_valid = v_q[rd_idx];
    assign rd_mac   = mac_q[rd_idx];
    assign rd_fid   = fid_q[rd_idx];
    assign rd_port  = port_q[rd_idx];

    // R5
    learn_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(v_q) <= $countones($past(v_q)) + 1);

    // R11
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!v_q[wr_idx] ||
                   (mac_q[wr_idx] == wr_mac && fid_q[wr_idx] == wr_fid)));
endmodule

// File: rtl/l2lu_ctrl.sv
// Lookup sequencer. It accepts one request, drops bad or PAUSE frames at
// once, and otherwise scans the learned table one entry per cycle. Along
// the way it records the first destination hit, the first source hit and the
// first free slot. It then learns or refreshes the source, resolves the
// egress mask and holds it until accepted.
// Assumes req_port < NPORTS and that the host table key follows da_q/fid_q.
module l2lu_ctrl
    import l2lu_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NPORTS = 5,
    parameter int FID_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [MAC_W-1:0]          req_da,
    input  logic [MAC_W-1:0]          req_sa,
    input  logic [$clog2(NPORTS)-1:0] req_port,
    input  logic [FID_W-1:0]          req_fid,
    input  logic                      req_err,
    output logic                      rsp_valid,
    input  logic                      rsp_ready,
    output logic [NPORTS-1:0]         rsp_ports,
    output logic [MAC_W-1:0]          key_da,
    output logic [FID_W-1:0]          key_fid,
    input  logic                      st_hit,
    input  logic [NPORTS-1:0]         st_ports,
    output logic [$clog2(DEPTH)-1:0]  rd_idx,
    input  logic                      rd_valid,
    input  logic [MAC_W-1:0]          rd_mac,
    input  logic [FID_W-1:0]          rd_fid,
    input  logic [$clog2(NPORTS)-1:0] rd_port,
    output logic                      wr_en,
    output logic [$clog2(DEPTH)-1:0]  wr_idx,
    output logic [MAC_W-1:0]          wr_mac,
    output logic [FID_W-1:0]          wr_fid,
    output logic [$clog2(NPORTS)-1:0] wr_port
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = $clog2(NPORTS);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    lu_state_e         state_q;
    logic [MAC_W-1:0]  da_q, sa_q;
    logic [PW-1:0]     sport_q;
    logic [FID_W-1:0]  fid_q;
    logic              bad_q;
    logic [IW-1:0]     idx_q;
    logic              dah_q, sah_q, frh_q;
    logic [PW-1:0]     daport_q;
    logic [IW-1:0]     saidx_q, fridx_q;
    logic [NPORTS-1:0] ports_q;
    logic              da_m, sa_m, free_m;
    logic [NPORTS-1:0] resolved;

    // Compare the entry under the scan pointer with both keys.
    assign da_m   = rd_valid && rd_mac == da_q && rd_fid == fid_q;
    assign sa_m   = rd_valid && rd_mac == sa_q && rd_fid == fid_q;
    assign free_m = !rd_valid;

    // Host hit first, then learned hit, otherwise flood minus ingress.
    always_comb begin
        if (st_hit)     resolved = st_ports;
        else if (dah_q) resolved = NPORTS'(1) << daport_q;
        else            resolved = {NPORTS{1'b1}} & ~(NPORTS'(1) << sport_q);
    end

    // Main sequencer: capture, scan, update, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LU_IDLE;
            da_q     <= '0;
            sa_q     <= '0;
            sport_q  <= '0;
            fid_q    <= '0;
            bad_q    <= 1'b0;
            idx_q    <= '0;
            dah_q    <= 1'b0;
            sah_q    <= 1'b0;
            frh_q    <= 1'b0;
            daport_q <= '0;
            saidx_q  <= '0;
            fridx_q  <= '0;
            ports_q  <= '0;
        end else begin
            case (state_q)
                LU_IDLE: begin
                    if (req_valid) begin
                        da_q    <= req_da;
                        sa_q    <= req_sa;
                        sport_q <= req_port;
                        fid_q   <= req_fid;
                        bad_q   <= req_err || (req_da == PAUSE_DA);
                        idx_q   <= '0;
                        dah_q   <= 1'b0;
                        sah_q   <= 1'b0;
                        frh_q   <= 1'b0;
                        ports_q <= '0;
                        state_q <= (req_err || req_da == PAUSE_DA) ? LU_RSP : LU_SCAN;
                    end
                end
                LU_SCAN: begin
                    if (da_m && !dah_q) begin
                        dah_q    <= 1'b1;
                        daport_q <= rd_port;
                    end
                    if (sa_m && !sah_q) begin
                        sah_q   <= 1'b1;
                        saidx_q <= idx_q;
                    end
                    if (free_m && !frh_q) begin
                        frh_q   <= 1'b1;
                        fridx_q <= idx_q;
                    end
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST) state_q <= LU_UPD;
                end
                LU_UPD: begin
                    ports_q <= resolved;
                    state_q <= LU_RSP;
                end
                LU_RSP: begin
                    if (rsp_ready) state_q <= LU_IDLE;
                end
                default: state_q <= LU_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == LU_IDLE);
    assign rsp_valid = (state_q == LU_RSP);
    assign rsp_ports = ports_q;
    assign key_da    = da_q;
    assign key_fid   = fid_q;
    assign rd_idx    = idx_q;

    // Learn into a free slot, or refresh the slot that hit.
    assign wr_en   = (state_q == LU_UPD) && (sah_q || frh_q);
    assign wr_idx  = sah_q ? saidx_q : fridx_q;
    assign wr_mac  = sa_q;
    assign wr_fid  = fid_q;
    assign wr_port = sport_q;

    // R12
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ports)));

    // R8
    bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && bad_q) |-> (rsp_ports == '0));
endmodule

// File: rtl/l2_lookup_engine.sv
// Top of the layer-2 lookup and learning engine: wires the sequencer to the
// host table and the learned table.
// Assumes ports are numbered 0..NPORTS-1 and one request is in flight.
module l2_lookup_engine
    import l2lu_pkg::*;
#(
    parameter int NPORTS   = 5,
    parameter int DYN_DEPTH = 16,
    parameter int ST_DEPTH = 8,
    parameter int FID_W    = 4,
    localparam int PW      = $clog2(NPORTS),
    localparam int SIW     = $clog2(ST_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [47:0]       req_da,
    input  logic [47:0]       req_sa,
    input  logic [PW-1:0]     req_port,
    input  logic [FID_W-1:0]  req_fid,
    input  logic              req_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [NPORTS-1:0] rsp_ports,
    input  logic              st_we,
    input  logic [SIW-1:0]    st_idx,
    input  logic              st_valid,
    input  logic [47:0]       st_mac,
    input  logic [NPORTS-1:0] st_ports,
    input  logic              st_use_fid,
    input  logic [FID_W-1:0]  st_fid,
    input  logic              age_tick
);
    localparam int IW = $clog2(DYN_DEPTH);

    logic [MAC_W-1:0]  key_da;
    logic [FID_W-1:0]  key_fid;
    logic              s_hit;
    logic [NPORTS-1:0] s_ports;
    logic [IW-1:0]     rd_idx, wr_idx;
    logic              rd_valid, wr_en;
    logic [MAC_W-1:0]  rd_mac, wr_mac;
    logic [FID_W-1:0]  rd_fid, wr_fid;
    logic [PW-1:0]     rd_port, wr_port;

    l2lu_ctrl #(.DEPTH(DYN_DEPTH), .NPORTS(NPORTS), .FID_W(FID_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_da(req_da), .req_sa(req_sa), .req_port(req_port),
        .req_fid(req_fid), .req_err(req_err),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ports(rsp_ports),
        .key_da(key_da), .key_fid(key_fid),
        .st_hit(s_hit), .st_ports(s_ports),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_mac(rd_mac),
        .rd_fid(rd_fid), .rd_port(rd_port),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mac(wr_mac),
        .wr_fid(wr_fid), .wr_port(wr_port)
    );

    l2lu_static_tbl #(.DEPTH(ST_DEPTH), .NPORTS(NPORTS), .FID_W(FID_W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .wr_en(st_we), .wr_idx(st_idx), .wr_valid(st_valid),
        .wr_mac(st_mac), .wr_ports(st_ports), .wr_use_fid(st_use_fid),
        .wr_fid(st_fid), .key_mac(key_da), .key_fid(key_fid),
        .hit(s_hit), .hit_ports(s_ports)
    );

    l2lu_dyn_tbl #(.DEPTH(DYN_DEPTH), .NPORTS(NPORTS), .FID_W(FID_W)) u_dyn (
        .clk(clk), .rst_n(rst_n), .age_tick(age_tick),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_mac(rd_mac),
        .rd_fid(rd_fid), .rd_port(rd_port),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mac(wr_mac),
        .wr_fid(wr_fid), .wr_port(wr_port)
    );
endmodule

// File: tb/test_l2_lookup_engine.sv
module test_l2_lookup_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [47:0] req_da = '0, req_sa = '0;
    logic [2:0]  req_port = '0;
    logic [3:0]  req_fid = '0;
    logic        req_err = 1'b0;
    logic        rsp_valid, rsp_ready = 1'b0;
    logic [4:0]  rsp_ports;
    logic        st_we = 1'b0, st_valid = 1'b0, st_use_fid = 1'b0;
    logic [2:0]  st_idx = '0;
    logic [47:0] st_mac = '0;
    logic [4:0]  st_ports = '0;
    logic [3:0]  st_fid = '0;
    logic        age_tick = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [4:0] res;

    always #2.5 clk = ~clk;

    l2_lookup_engine i_l2_lookup_engine (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_da(req_da), .req_sa(req_sa), .req_port(req_port),
        .req_fid(req_fid), .req_err(req_err),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ports(rsp_ports),
        .st_we(st_we), .st_idx(st_idx), .st_valid(st_valid),
        .st_mac(st_mac), .st_ports(st_ports), .st_use_fid(st_use_fid),
        .st_fid(st_fid), .age_tick(age_tick)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [47:0] smac(int p, int f);
        return 48'h02A0_0000_0000 + 48'(p * 256 + f);
    endfunction

    function automatic logic [4:0] flood(int p);
        return 5'h1F & ~(5'd1 << p);
    endfunction

    task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic lookup(logic [47:0] da, logic [47:0] sa, int p, int f,
                          logic err, output logic [4:0] r);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_da = da; req_sa = sa;
        req_port = 3'(p); req_fid = 4'(f); req_err = err;
        @(negedge clk);
        req_valid = 1'b0; req_err = 1'b0;
        while (!rsp_valid) @(negedge clk);
        r = rsp_ports;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic swrite(int idx, logic v, logic [47:0] m, logic [4:0] pm,
                          logic uf, int f);
        @(negedge clk);
        st_we = 1'b1; st_idx = 3'(idx); st_valid = v; st_mac = m;
        st_ports = pm; st_use_fid = uf; st_fid = 4'(f);
        @(negedge clk);
        st_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        age_tick = 1'b1;
        @(negedge clk);
        age_tick = 1'b0;
        @(negedge clk);
    endtask

    localparam logic [47:0] UNK = 48'h02FF_0000_0001;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 req_ready", {4'b0, req_ready}, 5'd1);
        chk("R13 rsp_valid", {4'b0, rsp_valid}, 5'd0);
        lookup(UNK, smac(9, 9), 1, 0, 1'b0, res);
        chk("R13 empty flood", res, flood(1));

        // R7 sweep: unknown destination from every port and two FIDs
        for (int p = 0; p < 5; p++)
            for (int f = 0; f < 2; f++) begin
                lookup(UNK + 48'(p), smac(p, f), p, f, 1'b0, res);
                chk("R7 flood", res, flood(p));
            end

        // R5 learned destinations return the stored port
        for (int p = 0; p < 5; p++) begin
            lookup(smac(p, 0), smac((p + 1) % 5, 0), (p + 1) % 5, 0, 1'b0, res);
            chk("R5 learned hit", res, 5'd1 << p);
        end
        lookup(smac(0, 0), smac(1, 1), 1, 1, 1'b0, res);
        chk("R5 fid mismatch", res, flood(1));

        // R6 station move
        lookup(UNK, smac(2, 0), 4, 0, 1'b0, res);
        lookup(smac(2, 0), smac(0, 0), 0, 0, 1'b0, res);
        chk("R6 moved port", res, 5'b10000);

        // R1 R2 host table priority and multi-bit masks
        swrite(0, 1'b1, smac(3, 0), 5'b00110, 1'b0, 0);
        lookup(smac(3, 0), smac(0, 0), 0, 0, 1'b0, res);
        chk("R1 host over learned", res, 5'b00110);
        swrite(2, 1'b1, smac(3, 0), 5'b00001, 1'b0, 0);
        lookup(smac(3, 0), smac(0, 0), 0, 5, 1'b0, res);
        chk("R2 lowest index any fid", res, 5'b00110);
        // R3 FID-qualified entry
        swrite(1, 1'b1, 48'h02BB_0000_0001, 5'b11000, 1'b1, 3);
        lookup(48'h02BB_0000_0001, smac(0, 3), 0, 3, 1'b0, res);
        chk("R3 fid match", res, 5'b11000);
        lookup(48'h02BB_0000_0001, smac(0, 0), 0, 0, 1'b0, res);
        chk("R3 fid differs", res, flood(0));

        // R4 source learned even when present in host table
        swrite(3, 1'b1, 48'h02CC_0000_0009, 5'b00001, 1'b0, 0);
        lookup(UNK, 48'h02CC_0000_0009, 3, 0, 1'b0, res);
        swrite(3, 1'b0, 48'h02CC_0000_0009, 5'b00001, 1'b0, 0);
        lookup(48'h02CC_0000_0009, smac(0, 0), 0, 0, 1'b0, res);
        chk("R4 learned behind host", res, 5'b01000);

        // R8 errored frame dropped and not learned
        lookup(smac(0, 0), 48'h02EE_0000_0001, 2, 0, 1'b1, res);
        chk("R8 drop", res, 5'b00000);
        lookup(48'h02EE_0000_0001, smac(0, 0), 0, 0, 1'b0, res);
        chk("R8 not learned", res, flood(0));

        // R9 PAUSE frame dropped and not learned
        lookup(48'h0180_C200_0001, 48'h02EE_0000_0002, 1, 0, 1'b0, res);
        chk("R9 drop", res, 5'b00000);
        lookup(48'h02EE_0000_0002, smac(0, 0), 0, 0, 1'b0, res);
        chk("R9 not learned", res, flood(0));

        // R12 response held while not accepted
        @(negedge clk);
        req_valid = 1'b1; req_da = smac(2, 0); req_sa = smac(0, 0);
        req_port = 3'd0; req_fid = 4'd0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        res = rsp_ports;
        repeat (5) @(negedge clk);
        chk("R12 held valid", {4'b0, rsp_valid}, 5'd1);
        chk("R12 held ports", rsp_ports, res);
        chk("R12 busy", {4'b0, req_ready}, 5'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R12 released", {4'b0, rsp_valid}, 5'd0);

        // R10 aging: flush, then survive two ticks, gone after three
        repeat (3) tick();
        lookup(smac(0, 0), smac(9, 1), 1, 0, 1'b0, res);
        chk("R10 flushed", res, flood(1));
        lookup(UNK, 48'h02DD_0000_0001, 2, 0, 1'b0, res);
        tick(); tick();
        lookup(48'h02DD_0000_0001, smac(9, 2), 0, 0, 1'b0, res);
        chk("R10 lag two alive", res, 5'b00100);
        tick();
        lookup(48'h02DD_0000_0001, smac(9, 3), 0, 0, 1'b0, res);
        chk("R10 lag three gone", res, flood(0));
        // R6 refresh keeps an entry alive
        lookup(UNK, 48'h02DD_0000_0002, 3, 0, 1'b0, res);
        tick(); tick();
        lookup(UNK, 48'h02DD_0000_0002, 3, 0, 1'b0, res);
        tick(); tick();
        lookup(48'h02DD_0000_0002, smac(9, 4), 0, 0, 1'b0, res);
        chk("R6 refreshed", res, 5'b01000);

        // R11 full table
        repeat (3) tick();
        for (int i = 0; i < 16; i++)
            lookup(UNK, 48'h02F0_0000_0000 + 48'(i), i % 5, 0, 1'b0, res);
        lookup(UNK, 48'h02F0_0000_0010, 4, 0, 1'b0, res);
        lookup(48'h02F0_0000_0010, 48'h02F0_0000_0001, 1, 0, 1'b0, res);
        chk("R11 not learned", res, flood(1));
        lookup(48'h02F0_0000_0000, 48'h02F0_0000_0001, 1, 0, 1'b0, res);
        chk("R11 first kept", res, 5'b00001);
        lookup(48'h02F0_0000_000F, 48'h02F0_0000_0001, 1, 0, 1'b0, res);
        chk("R11 last kept", res, 5'b00001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule